// File: doc/BRIEF.md
# Auto-Scrolling Test Pattern Sequencer

This block decides which test pattern a video pattern generator shows in each frame. Software programs a short list of up to four 4-bit pattern codes, packed two to a byte. It also sets how many list entries take part, how long each entry stays on screen, and two enable bits. An external video timing source pulses `frame_start` once per frame. At each pulse the sequencer counts frames and, when the dwell time runs out, moves to the next list entry. After the last active entry it returns to the first.

Register writes go through a write-strobe, address and data port into a staging copy. The staging copy moves into the working copy only when a frame-start pulse arrives, so a pattern never changes partway through a frame. The pixel colour logic downstream reads `pattern_code` and turns it into colours. For example, 3 is red, 4 is green and 5 is blue.

Top module: `pattern_scroll_seq`

## Requirements
- R1: After reset, and whenever the working global-enable bit is clear, `pattern_code` is 0. A frame-start pulse that commits a cleared enable bit brings `pattern_code` to 0.
- R2: Register addresses are: 0 = control (bit 0 global enable), 1 = configuration (bit 0 scroll enable), 2 = dwell timer, 3 = active slot count, 4 = slot byte for slots 1 and 2, 5 = slot byte for slots 3 and 4. Writes to addresses 6 and 7 change nothing.
- R3: In each slot byte, bits 3:0 hold the code of the odd slot (slot 1 or 3) and bits 7:4 hold the code of the even slot (slot 2 or 4).
- R4: Each slot is shown for twice the dwell-timer value, counted in frame-start pulses. A timer value of 0 acts as 1, which gives two frames.
- R5: Slots are shown in order 1, 2, 3, 4, and only the first N take part, where N is the slot count. After slot N the sequence returns to slot 1. Slots above N are never shown.
- R6: A slot count of 0 acts as 1. A slot count above 4 acts as 4.
- R7: A write takes effect at the first frame-start pulse after the write cycle. A write in the same cycle as a pulse waits for the following pulse. `pattern_code` changes only in the cycle that follows a sampled frame-start pulse.
- R8: When scrolling starts, either from the disabled state or from scrolling off, slot 1 is shown at the enabling pulse and stays for a full dwell.
- R9: With scrolling disabled and the generator enabled, `pattern_code` is the slot 1 code and the frame counter stays at zero.
- R10: If a new slot count leaves the current slot outside the active range, the sequence restarts at slot 1 at that frame boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| frame_start | input | 1 | One-cycle pulse at the start of each video frame |
| pattern_code | output | 4 | Code of the pattern for the current frame |

## Verification
Every result of this block is due one clock edge after the edge that samples a `frame_start` pulse. The sampled pulse commits the staged registers and steps the counters, and `pattern_code` is decoded from those registers. For each pulse, the driver pushes the code expected from the bench's own model of the staging and dwell rules. The monitor waits for the sampling edge, then pops and compares on the following falling edge. Checks for writes that are still pending are made on falling edges between pulses, when the output has to keep its old value.

// File: rtl/pscroll_pkg.sv
package pscroll_pkg;
  parameter int DATA_W    = 8;
  parameter int ADDR_W    = 3;
  parameter int TIMER_W   = 8;
  parameter int COUNT_W   = 8;
  parameter int CODE_W    = 4;
  parameter int MAX_SLOTS = 4;

  localparam int SLOTS_PER_BYTE = DATA_W / CODE_W;
  localparam int SLOT_BYTES     = MAX_SLOTS / SLOTS_PER_BYTE;
  localparam int IDX_W          = $clog2(MAX_SLOTS);
  localparam int LIMIT_W        = TIMER_W + 1;

  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_TIMER = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_SLOT0 = ADDR_W'(4);

  typedef struct packed {
    logic               gen_en;
    logic               scroll_en;
    logic [TIMER_W-1:0] timer;
    logic [COUNT_W-1:0] count;
  } cfg_t;

  // Frames per slot: two per timer unit, a zero timer behaves as one unit.
  function automatic logic [LIMIT_W-1:0] dwell_limit(input logic [TIMER_W-1:0] t);
    if (t == '0) return LIMIT_W'(2);
    return {t, 1'b0};
  endfunction

  // Slots taking part in the cycle, clamped to 1..MAX_SLOTS.
  function automatic logic [IDX_W:0] slot_total(input logic [COUNT_W-1:0] c);
    if (c == '0) return (IDX_W+1)'(1);
    if (c > COUNT_W'(MAX_SLOTS)) return (IDX_W+1)'(MAX_SLOTS);
    return (IDX_W+1)'(c);
  endfunction
endpackage

// File: rtl/pscroll_regs.sv
module pscroll_regs
  import pscroll_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [ADDR_W-1:0]                wr_addr,
  input  logic [DATA_W-1:0]                wr_data,
  input  logic                             frame_start,
  output cfg_t                             stg_cfg,
  output cfg_t                             act_cfg,
  output logic [SLOT_BYTES-1:0][DATA_W-1:0] act_slots
);
  cfg_t                              stg_cfg_d, act_cfg_d;
  logic [SLOT_BYTES-1:0][DATA_W-1:0] stg_slots, stg_slots_d, act_slots_d;

  // Staging copy: software writes land here immediately.
  always_comb begin
    stg_cfg_d   = stg_cfg;
    stg_slots_d = stg_slots;
    if (wr_en) begin
      case (wr_addr)
        A_CTRL:  stg_cfg_d.gen_en    = wr_data[0];
        A_CFG:   stg_cfg_d.scroll_en = wr_data[0];
        A_TIMER: stg_cfg_d.timer     = wr_data[TIMER_W-1:0];
        A_COUNT: stg_cfg_d.count     = wr_data[COUNT_W-1:0];
        default: ;
      endcase
      for (int b = 0; b < SLOT_BYTES; b++) begin
        if (wr_addr == A_SLOT0 + ADDR_W'(b)) stg_slots_d[b] = wr_data;
      end
    end
  end

  // Working copy: refreshed only at a frame boundary.
  always_comb begin
    act_cfg_d   = act_cfg;
    act_slots_d = act_slots;
    if (frame_start) begin
      act_cfg_d   = stg_cfg;
      act_slots_d = stg_slots;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_cfg   <= '0;
      stg_slots <= '0;
      act_cfg   <= '0;
      act_slots <= '0;
    end else begin
      stg_cfg   <= stg_cfg_d;
      stg_slots <= stg_slots_d;
      act_cfg   <= act_cfg_d;
      act_slots <= act_slots_d;
    end
  end

  AST_ACTIVE_FRAME_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> ($stable(act_cfg) && $stable(act_slots))); // R7
endmodule

// File: rtl/pscroll_step.sv
module pscroll_step
  import pscroll_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_start,
  input  cfg_t               cur_cfg,
  input  cfg_t               new_cfg,
  output logic [IDX_W-1:0]   slot_idx,
  output logic [LIMIT_W-1:0] frame_cnt
);
  logic [IDX_W-1:0]   slot_d;
  logic [LIMIT_W-1:0] cnt_d;
  logic [LIMIT_W-1:0] new_limit, cnt_inc;
  logic [IDX_W:0]     new_total, slot_ext, slot_inc;
  logic               cur_run, new_run;

  assign new_limit = dwell_limit(new_cfg.timer);
  assign new_total = slot_total(new_cfg.count);
  assign cnt_inc   = frame_cnt + LIMIT_W'(1);
  assign slot_ext  = {1'b0, slot_idx};
  assign slot_inc  = slot_ext + (IDX_W+1)'(1);
  assign cur_run   = cur_cfg.gen_en & cur_cfg.scroll_en;
  assign new_run   = new_cfg.gen_en & new_cfg.scroll_en;

  always_comb begin
    slot_d = slot_idx;
    cnt_d  = frame_cnt;
    if (frame_start) begin
      if (!cur_run || !new_run) begin
        slot_d = '0;
        cnt_d  = '0;
      end else if (slot_ext >= new_total) begin
        slot_d = '0;
        cnt_d  = '0;
      end else if (cnt_inc >= new_limit) begin
        cnt_d  = '0;
        slot_d = (slot_inc >= new_total) ? '0 : slot_inc[IDX_W-1:0];
      end else begin
        cnt_d  = cnt_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_idx  <= '0;
      frame_cnt <= '0;
    end else if (frame_start) begin
      slot_idx  <= slot_d;
      frame_cnt <= cnt_d;
    end
  end

  AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    frame_cnt < dwell_limit(cur_cfg.timer)); // R4
  AST_SLOT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, slot_idx} < slot_total(cur_cfg.count)); // R5
  AST_IDLE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !(cur_cfg.gen_en && cur_cfg.scroll_en) |-> (frame_cnt == '0 && slot_idx == '0)); // R9
  AST_STEP_FRAME_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> ($stable(slot_idx) && $stable(frame_cnt))); // R7
endmodule

// File: rtl/pattern_scroll_seq.sv
module pattern_scroll_seq
  import pscroll_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              frame_start,
  output logic [CODE_W-1:0] pattern_code
);
  logic [1:0]                        rst_sync;
  logic                              rst_int_n;
  cfg_t                              stg_cfg, act_cfg;
  logic [SLOT_BYTES-1:0][DATA_W-1:0] act_slots;
  logic [IDX_W-1:0]                  slot_idx, sel_idx;
  logic [LIMIT_W-1:0]                frame_cnt;
  logic [MAX_SLOTS-1:0][CODE_W-1:0]  slot_codes;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  pscroll_regs u_regs (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .frame_start(frame_start),
    .stg_cfg(stg_cfg), .act_cfg(act_cfg), .act_slots(act_slots)
  );

  pscroll_step u_step (
    .clk(clk), .rst_n(rst_int_n), .frame_start(frame_start),
    .cur_cfg(act_cfg), .new_cfg(stg_cfg),
    .slot_idx(slot_idx), .frame_cnt(frame_cnt)
  );

  // Unpack slot codes: odd slot in the low nibble, even slot in the high one.
  for (genvar s = 0; s < MAX_SLOTS; s++) begin : g_unpack
    assign slot_codes[s] = act_slots[s / SLOTS_PER_BYTE][(s % SLOTS_PER_BYTE) * CODE_W +: CODE_W];
  end

  assign sel_idx      = act_cfg.scroll_en ? slot_idx : '0;
  assign pattern_code = act_cfg.gen_en ? slot_codes[sel_idx] : '0;

  AST_OUT_FRAME_ONLY: assert property (@(posedge clk) disable iff (!rst_int_n)
    !frame_start |=> $stable(pattern_code)); // R7
  AST_OFF_GIVES_ZERO: assert property (@(posedge clk) disable iff (!rst_int_n)
    !act_cfg.gen_en |-> (pattern_code == '0)); // R1
endmodule

// File: tb/pattern_scroll_seq_tb_top.sv
module pattern_scroll_seq_tb_top;
  localparam time CLK_HALF = 10ns;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       frame_start = 1'b0;
  logic [3:0] pattern_code;

  int total = 0;
  int fails = 0;
  bit done = 0;

  int    exp_q[$];
  string tag_q[$];

  // Bench model of the register and sequencing rules.
  int s_en, s_sc, s_t, s_c;
  int s_sl[2];
  int a_en, a_sc, a_t, a_c;
  int a_sl[2];
  int m_cnt, m_slot;

  pattern_scroll_seq dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .frame_start(frame_start), .pattern_code(pattern_code)
  );

  always #(CLK_HALF) clk = ~clk;

  function automatic int m_total(int c);
    if (c == 0) return 1;
    if (c > 4) return 4;
    return c;
  endfunction

  function automatic int m_limit(int t);
    return (t == 0) ? 2 : 2 * t;
  endfunction

  function automatic int m_code();
    int s;
    if (a_en == 0) return 0;
    s = (a_sc != 0) ? m_slot : 0;
    return (s % 2 == 1) ? ((a_sl[s/2] >> 4) & 15) : (a_sl[s/2] & 15);
  endfunction

  task automatic m_write(int a, int d);
    case (a)
      0: s_en = d & 1;
      1: s_sc = d & 1;
      2: s_t  = d;
      3: s_c  = d;
      4: s_sl[0] = d;
      5: s_sl[1] = d;
      default: ;
    endcase
  endtask

  task automatic m_step();
    if (s_en == 0 || s_sc == 0 || a_en == 0 || a_sc == 0) begin
      m_cnt = 0; m_slot = 0;
    end else if (m_slot >= m_total(s_c)) begin
      m_cnt = 0; m_slot = 0;
    end else if (m_cnt + 1 >= m_limit(s_t)) begin
      m_cnt = 0;
      m_slot = (m_slot + 1 >= m_total(s_c)) ? 0 : m_slot + 1;
    end else begin
      m_cnt = m_cnt + 1;
    end
    a_en = s_en; a_sc = s_sc; a_t = s_t; a_c = s_c;
    a_sl[0] = s_sl[0]; a_sl[1] = s_sl[1];
  endtask

  task automatic chk(int act, int exp, string tag);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: pattern_code=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
    m_write(a, d);
  endtask

  // Driver: one frame pulse, expected code pushed for the monitor.
  task automatic frame(string tag);
    @(negedge clk);
    frame_start = 1'b1;
    m_step();
    exp_q.push_back(m_code());
    tag_q.push_back(tag);
    @(negedge clk);
    frame_start = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic frame_and_write(int a, int d, string tag);
    @(negedge clk);
    frame_start = 1'b1;
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
    m_step();
    m_write(a, d);
    exp_q.push_back(m_code());
    tag_q.push_back(tag);
    @(negedge clk);
    frame_start = 1'b0;
    wr_en = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic frames(int n, string tag);
    for (int i = 0; i < n; i++) frame(tag);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  // Monitor: result due one edge after a sampled pulse.
  initial begin
    forever begin
      @(posedge clk);
      if (frame_start === 1'b1) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          total++; fails++;
          $display("FAIL R7: pattern_code=%0d expected=<no item>", pattern_code);
        end else begin
          chk(int'(pattern_code), exp_q.pop_front(), tag_q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: pattern_code=%0d expected=<run complete>", pattern_code);
      summary();
    end
  end

  initial begin
    s_en = 0; s_sc = 0; s_t = 0; s_c = 0; s_sl[0] = 0; s_sl[1] = 0;
    a_en = 0; a_sc = 0; a_t = 0; a_c = 0; a_sl[0] = 0; a_sl[1] = 0;
    m_cnt = 0; m_slot = 0;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(int'(pattern_code), 0, "R1 reset");

    // Main cycle: dwell 4 frames, three slots, slot 4 holds 6 and must not show.
    wr(2, 2); wr(3, 3); wr(4, 8'h43); wr(5, 8'h65); wr(1, 1);
    chk(int'(pattern_code), 0, "R7 staged while off");
    wr(0, 1);
    chk(int'(pattern_code), 0, "R7 enable pending");
    frame("R8 first frame");
    chk(int'(pattern_code), 3, "R8 slot1 first");
    frames(14, "R5 sequence");
    chk(int'(pattern_code), 3, "R5 wrap to slot1");

    // Four slots: even slot code from the high nibble.
    wr(3, 4);
    frames(16, "R3 four slots");

    // Lowering the count while on a slot beyond it restarts at slot 1.
    for (int i = 0; i < 20 && m_slot != 3; i++) frame("R5 reach slot4");
    chk(m_slot, 3, "R10 precondition");
    wr(3, 2);
    frame("R10 restart");
    chk(int'(pattern_code), 3, "R10 slot1 after shrink");
    frames(8, "R10 two slots");

    // Count clamps.
    wr(3, 0);
    frames(6, "R6 count zero");
    chk(int'(pattern_code), 3, "R6 zero acts as one");
    wr(3, 9);
    frames(16, "R6 count clamp");

    // Write in the same cycle as a pulse waits one more frame.
    frame_and_write(4, 8'h77, "R7 same-cycle write");
    frames(3, "R7 after same-cycle");
    wr(4, 8'h21);
    chk(int'(pattern_code), m_code(), "R7 mid-frame hold");
    frames(4, "R7 applied");

    // Scroll off: slot 1 code, counter parked.
    wr(1, 0);
    frames(5, "R9 scroll off");
    chk(int'(pattern_code), 1, "R9 slot1 code");
    wr(1, 1);
    frames(6, "R8 scroll resume");

    // Zero timer means two frames.
    wr(2, 0); wr(3, 2); wr(4, 8'h43);
    frames(9, "R4 zero timer");

    // Unused addresses change nothing.
    wr(6, 8'hFF); wr(7, 8'hFF);
    frames(3, "R2 unused address");

    // Sixty-frame dwell.
    wr(2, 8'h1E);
    frames(125, "R4 sixty frames");

    // Global disable.
    wr(0, 0);
    chk(int'(pattern_code), m_code(), "R7 disable pending");
    frame("R1 disabled");
    chk(int'(pattern_code), 0, "R1 disabled output");
    frames(3, "R1 stays off");

    repeat (4) @(negedge clk);
    chk(exp_q.size(), 0, "R7 all results seen");
    done = 1;
    summary();
  end
endmodule